// File: doc/BRIEF.md
# Configuration address/data port decoder

This block gives a host an indirect path into the configuration storage of a set of device slots. The host first fills a 32-bit address latch with an enable flag, a bus number, a device number, a function number and a register offset. It then reads or writes through a four-byte data window. The block decodes the latched target and checks that the device exists. If it does, the block issues one request on a simple storage interface. If it does not, the block fills the read data with all-ones and drops writes.

A second, memory-mapped path reaches the same storage. That path takes the whole target from the offset of the access and treats the enable flag as always set. The sub-dword byte offset on the data window comes from the byte lane the host touches, not from the low two bits of the latch. Every read returns its data one cycle after the request, packed into the low bytes. Writes return nothing.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the latch reads as zero, `rsp_valid` is 0 and `cfg_req` is 0.
- R2: A write to space 0 at lane k = `req_offset[1:0]` with clipped size s sets latch byte j to byte (j-k) of `req_wdata`, for k <= j < min(k+s, 4). Every other latch byte keeps its value.
- R3: A read of space 0 at lane k returns latch byte k+i in `rsp_rdata` byte i, for i < s and k+i < 4. All other bytes are 0.
- R4: An access to space 1 at lane k drives `cfg_reg` = {latch[7:2], k}, `cfg_dev` = latch[15:11], `cfg_write` = `req_write` and `cfg_wdata` = `req_wdata`, all in the request cycle.
- R5: A `req_size` above 4 is clipped to 4, and `cfg_size` carries the clipped size. Size 0 touches no byte and issues no request.
- R6: A target is present only when all of these hold: the enable flag (bit 31) is 1, the bus (bits 23:16) equals `BUS_ID`, the function (bits 10:8) is 0, and bit `dev` of `DEV_MAP` is 1.
- R7: A read of a present target returns the low s bytes of `cfg_rdata`. All higher bytes are 0.
- R8: A read of an absent target returns 0xFF in each of the low s bytes and 0 above them.
- R9: A write to an absent target raises no `cfg_req`.
- R10: Space 2 or 3 (memory-mapped window) takes the bus, device, function and register from `req_offset` bits 23:16, 15:11, 10:8 and 7:0, and forces the enable flag to 1.
- R11: `rsp_valid` is 1 exactly one cycle after each accepted read, and is 0 after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | 0 latch window, 1 data window, 2/3 memory-mapped window |
| req_offset | input | 24 | Byte offset in the window; full target on the memory-mapped window |
| req_size | input | 4 | Access size in bytes, clipped to 4 |
| req_wdata | input | 32 | Write data, low byte first |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, low byte first |
| cfg_req | output | 1 | Storage access strobe |
| cfg_write | output | 1 | Storage write |
| cfg_dev | output | 5 | Target device slot |
| cfg_reg | output | 8 | Byte offset in the slot's space |
| cfg_size | output | 3 | Bytes accessed (1 to 4) |
| cfg_wdata | output | 32 | Storage write data |
| cfg_rdata | input | 32 | Storage read data, valid in the request cycle |

## Verification
Two events can land in the same cycle: a data-window access that starts at the edge where a latch write lands, and size clipping together with the all-ones fill on an absent target. The bench issues data-window accesses back to back with the latch writes that retarget them. It also sends oversized reads to absent slots, disabled targets, wrong functions and wrong buses. For each access, the reference model recomputes presence and the byte mask from its own copy of the latch bytes. It then judges `cfg_req`, the request fields in the request cycle, and the response one cycle later.

// File: rtl/cfg_port_decoder_pkg.sv
package cfg_port_decoder_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int REG_W   = 8;
  localparam int SIZE_W  = 3;

  // Clip a requested byte count to one dword.
  function automatic logic [SIZE_W-1:0] clip_size(input logic [3:0] s);
    return (s > 4'd4) ? 3'd4 : s[SIZE_W-1:0];
  endfunction

  // Window lanes touched by an access starting at lane k with sz bytes.
  function automatic logic [LANES-1:0] window_lanes(input logic [1:0] k,
                                                    input logic [SIZE_W-1:0] sz);
    logic [LANES-1:0] m;
    for (int j = 0; j < LANES; j++)
      m[j] = (j >= int'(k)) && ((j - int'(k)) < int'(sz));
    return m;
  endfunction

  // All-ones in the low sz bytes.
  function automatic logic [DATA_W-1:0] byte_fill(input logic [SIZE_W-1:0] sz);
    logic [DATA_W-1:0] f;
    for (int i = 0; i < LANES; i++)
      f[8*i +: 8] = (i < int'(sz)) ? 8'hFF : 8'h00;
    return f;
  endfunction
endpackage

// File: rtl/cfg_port_latch.sv
module cfg_port_latch
  import cfg_port_decoder_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [DATA_W-1:0] wdata_aligned,
  output logic [DATA_W-1:0] q
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[8*j +: 8] <= 8'h00;
      else if (wr_en && lane_mask[j])
        q[8*j +: 8] <= wdata_aligned[8*j +: 8];
    end
  end
endmodule

// File: rtl/cfg_port_target.sv
module cfg_port_target
  import cfg_port_decoder_pkg::*;
#(
  parameter logic [BUS_W-1:0]         BUS_ID  = 8'h00,
  parameter int                       NDEV    = 32,
  parameter logic [NDEV-1:0]          DEV_MAP = 32'h0000_000B
) (
  input  logic             en,
  input  logic [BUS_W-1:0] bus,
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  output logic             present
);
  logic bus_hit, fn_hit, slot_hit;
  assign bus_hit  = (bus == BUS_ID);
  assign fn_hit   = (fn == '0);
  assign slot_hit = DEV_MAP[dev];
  assign present  = en && bus_hit && fn_hit && slot_hit;
endmodule

// File: rtl/cfg_port_resp.sv
module cfg_port_resp
  import cfg_port_decoder_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data_in,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= load;
      if (load) data_q <= data_in;
    end
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_decoder_pkg::*;
#(
  parameter logic [BUS_W-1:0] BUS_ID  = 8'h00,
  parameter logic [31:0]      DEV_MAP = 32'h0000_000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_space,
  input  logic [23:0]       req_offset,
  input  logic [3:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cfg_req,
  output logic              cfg_write,
  output logic [DEV_W-1:0]  cfg_dev,
  output logic [REG_W-1:0]  cfg_reg,
  output logic [SIZE_W-1:0] cfg_size,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata
);
  localparam int NDEV = 1 << DEV_W;

  // Access classification
  logic              is_latch, is_mmio;
  logic [1:0]        lane_k;
  logic [SIZE_W-1:0] size_c;
  logic [LANES-1:0]  lane_mask;
  logic [DATA_W-1:0] fill_mask;

  assign is_latch  = (req_space == 2'b00);
  assign is_mmio   = req_space[1];
  assign lane_k    = req_offset[1:0];
  assign size_c    = clip_size(req_size);
  assign lane_mask = window_lanes(lane_k, size_c);
  assign fill_mask = byte_fill(size_c);

  // Address latch
  logic              lat_wr;
  logic [DATA_W-1:0] latch_q;
  assign lat_wr = req_valid && req_write && is_latch;

  cfg_port_latch u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (lat_wr),
    .lane_mask    (lane_mask),
    .wdata_aligned(req_wdata << {lane_k, 3'b000}),
    .q            (latch_q)
  );

  // Target selection: latched address or memory-mapped offset
  logic             tgt_en, tgt_present;
  logic [BUS_W-1:0] tgt_bus;
  logic [DEV_W-1:0] tgt_dev;
  logic [FN_W-1:0]  tgt_fn;
  logic [REG_W-1:0] tgt_reg;

  assign tgt_en  = is_mmio ? 1'b1               : latch_q[31];
  assign tgt_bus = is_mmio ? req_offset[23:16]  : latch_q[23:16];
  assign tgt_dev = is_mmio ? req_offset[15:11]  : latch_q[15:11];
  assign tgt_fn  = is_mmio ? req_offset[10:8]   : latch_q[10:8];
  assign tgt_reg = is_mmio ? req_offset[7:0]    : {latch_q[7:2], lane_k};

  cfg_port_target #(
    .BUS_ID (BUS_ID),
    .NDEV   (NDEV),
    .DEV_MAP(DEV_MAP)
  ) u_target (
    .en     (tgt_en),
    .bus    (tgt_bus),
    .dev    (tgt_dev),
    .fn     (tgt_fn),
    .present(tgt_present)
  );

  // Storage request
  logic cfg_access;
  assign cfg_access = req_valid && !is_latch && tgt_present && (size_c != '0);
  assign cfg_req    = cfg_access;
  assign cfg_write  = cfg_access && req_write;
  assign cfg_dev    = tgt_dev;
  assign cfg_reg    = tgt_reg;
  assign cfg_size   = size_c;
  assign cfg_wdata  = req_wdata;

  // Read data selection
  logic              rd_load;
  logic [DATA_W-1:0] rd_next;
  assign rd_load = req_valid && !req_write;

  always_comb begin
    if (is_latch)
      rd_next = (latch_q >> {lane_k, 3'b000}) & fill_mask;
    else if (tgt_present)
      rd_next = cfg_rdata & fill_mask;
    else
      rd_next = fill_mask;
  end

  cfg_port_resp u_resp (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (rd_load),
    .data_in(rd_next),
    .valid_q(rsp_valid),
    .data_q (rsp_rdata)
  );
endmodule

// File: rtl/cfg_port_decoder_checker.sv
module cfg_port_decoder_checker #(
  parameter logic [7:0]  BUS_ID  = 8'h00,
  parameter logic [31:0] DEV_MAP = 32'h0000_000B
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_space,
  input logic [23:0] req_offset,
  input logic [3:0]  req_size,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        cfg_req,
  input logic [7:0]  cfg_reg,
  input logic [2:0]  cfg_size,
  input logic        present,
  input logic        lat_wr,
  input logic [3:0]  lanes,
  input logic [31:0] latch_q
);
  assert_read_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_no_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);

  assert_absent_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !present |-> !cfg_req);

  assert_size_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_size != 3'd0 && cfg_size <= 3'd4));

  assert_lane_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && req_space == 2'b01) |-> (cfg_reg[1:0] == req_offset[1:0]));

  assert_absent_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_space != 2'b00 && !present && req_size != 4'd0)
      |=> (rsp_rdata[7:0] == 8'hFF));

  assert_latch_lane_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_wr && !lanes[0]) |=> $stable(latch_q[7:0]));

  assert_latch_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_wr |=> $stable(latch_q));

  assert_disabled_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'b01 && !latch_q[31]) |-> !cfg_req);

  assert_mmio_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space[1] && req_offset[23:16] == BUS_ID &&
     req_offset[10:8] == 3'd0 && DEV_MAP[req_offset[15:11]] && req_size != 4'd0)
      |-> cfg_req);
endmodule

bind cfg_port_decoder cfg_port_decoder_checker #(
  .BUS_ID (BUS_ID),
  .DEV_MAP(DEV_MAP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_space (req_space),
  .req_offset(req_offset),
  .req_size  (req_size),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .cfg_req   (cfg_req),
  .cfg_reg   (cfg_reg),
  .cfg_size  (cfg_size),
  .present   (tgt_present),
  .lat_wr    (lat_wr),
  .lanes     (lane_mask),
  .latch_q   (latch_q)
);

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;
  localparam logic [7:0]  BUS_ID  = 8'h00;
  localparam logic [31:0] DEV_MAP = 32'h0000_000B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_space = 2'b00;
  logic [23:0] req_offset = '0;
  logic [3:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, cfg_req, cfg_write;
  logic [31:0] rsp_rdata, cfg_wdata, cfg_rdata;
  logic [4:0]  cfg_dev;
  logic [7:0]  cfg_reg;
  logic [2:0]  cfg_size;

  always #5 clk = ~clk;

  // Storage model: pattern derived from the request fields
  assign cfg_rdata = {cfg_reg, 3'b101, cfg_dev, ~cfg_reg, 8'hC3};

  cfg_port_decoder #(.BUS_ID(BUS_ID), .DEV_MAP(DEV_MAP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_space(req_space), .req_offset(req_offset), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_req(cfg_req), .cfg_write(cfg_write), .cfg_dev(cfg_dev),
    .cfg_reg(cfg_reg), .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int checks = 0, errors = 0;
  logic [7:0] lb [4] = '{8'h00, 8'h00, 8'h00, 8'h00};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, logic w, logic [1:0] sp, logic [23:0] off,
                        logic [3:0] size, logic [31:0] wd);
    int sz, k;
    logic en, pres, exp_req;
    logic [7:0] bus, rg;
    logic [4:0] dv;
    logic [2:0] fn;
    logic [31:0] fill, exp_rd;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_space = sp;
    req_offset = off; req_size = size; req_wdata = wd;
    sz = (size > 4'd4) ? 4 : int'(size);
    k  = int'(off[1:0]);
    fill = '0;
    for (int i = 0; i < sz; i++) fill[8*i +: 8] = 8'hFF;
    exp_rd = '0; pres = 1'b0;
    if (sp == 2'b00) begin
      for (int i = 0; i < sz; i++)
        if (k + i < 4) exp_rd[8*i +: 8] = lb[k+i];
    end else begin
      if (sp[1]) begin
        en = 1'b1; bus = off[23:16]; dv = off[15:11]; fn = off[10:8]; rg = off[7:0];
      end else begin
        en = lb[3][7]; bus = lb[2]; dv = lb[1][7:3]; fn = lb[1][2:0];
        rg = {lb[0][7:2], off[1:0]};
      end
      pres = en && (bus == BUS_ID) && (fn == 3'd0) && DEV_MAP[dv];
      exp_rd = pres ? ({rg, 3'b101, dv, ~rg, 8'hC3} & fill) : fill;
    end
    exp_req = (sp != 2'b00) && pres && (sz != 0);
    #2;
    chk({tag, " cfg_req"}, {31'd0, cfg_req}, {31'd0, exp_req});
    if (exp_req) begin
      chk({tag, " cfg_write"}, {31'd0, cfg_write}, {31'd0, w});
      chk({tag, " cfg_dev"}, {27'd0, cfg_dev}, {27'd0, dv});
      chk({tag, " cfg_reg"}, {24'd0, cfg_reg}, {24'd0, rg});
      chk({tag, " cfg_size"}, {29'd0, cfg_size}, 32'(sz));
      if (w) chk({tag, " cfg_wdata"}, cfg_wdata, wd);
    end
    @(posedge clk);
    if (sp == 2'b00 && w)
      for (int j = 0; j < 4; j++)
        if (j >= k && j - k < sz) lb[j] = wd[8*(j-k) +: 8];
    #1;
    chk({tag, " rsp_valid"}, {31'd0, rsp_valid}, {31'd0, !w});
    if (!w) chk({tag, " rsp_rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    #2;
    chk({tag, " cfg_req idle"}, {31'd0, cfg_req}, 32'd0);
    @(posedge clk); #1;
    chk({tag, " rsp_valid idle"}, {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R11 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R1 reset cfg_req", {31'd0, cfg_req}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    access("R1 latch zero", 1'b0, 2'd0, 24'd0, 4'd4, 32'd0);

    // dev 1, fn 0, bus 0, reg 0x10, enabled
    access("R2 latch full write", 1'b1, 2'd0, 24'd0, 4'd4, 32'h8000_0810);
    access("R3 latch readback", 1'b0, 2'd0, 24'd0, 4'd4, 32'd0);
    access("R2 lane2 write", 1'b1, 2'd0, 24'd2, 4'd1, 32'h1234_56AA);
    access("R3 lane2 read past end", 1'b0, 2'd0, 24'd2, 4'd4, 32'd0);
    access("R2 lane2 restore", 1'b1, 2'd0, 24'd2, 4'd1, 32'h0000_0000);
    access("R3 lane1 read", 1'b0, 2'd0, 24'd1, 4'd2, 32'd0);

    access("R7 data read k0", 1'b0, 2'd1, 24'd0, 4'd4, 32'd0);
    access("R4 data read k3", 1'b0, 2'd1, 24'd3, 4'd1, 32'd0);
    access("R5 clipped read", 1'b0, 2'd1, 24'd2, 4'd7, 32'd0);
    access("R4 data write k1", 1'b1, 2'd1, 24'd1, 4'd2, 32'hDEAD_BEEF);
    access("R5 size zero", 1'b0, 2'd1, 24'd0, 4'd0, 32'd0);
    idle("R11");

    // retarget to dev 2 (absent) right before accesses
    access("R2 retarget dev2", 1'b1, 2'd0, 24'd1, 4'd1, 32'h0000_0010);
    access("R8 absent read", 1'b0, 2'd1, 24'd0, 4'd3, 32'd0);
    access("R8 absent clipped", 1'b0, 2'd1, 24'd1, 4'd9, 32'd0);
    access("R9 absent write", 1'b1, 2'd1, 24'd0, 4'd4, 32'h1111_2222);
    access("R2 dev3 fn1", 1'b1, 2'd0, 24'd1, 4'd1, 32'h0000_0019);
    access("R6 wrong function", 1'b0, 2'd1, 24'd0, 4'd4, 32'd0);
    access("R2 dev3 fn0", 1'b1, 2'd0, 24'd1, 4'd1, 32'h0000_0018);
    access("R6 dev3 present", 1'b0, 2'd1, 24'd2, 4'd2, 32'd0);
    access("R2 bus5", 1'b1, 2'd0, 24'd2, 4'd1, 32'h0000_0005);
    access("R6 wrong bus", 1'b0, 2'd1, 24'd0, 4'd4, 32'd0);
    access("R9 wrong bus write", 1'b1, 2'd1, 24'd0, 4'd4, 32'h3333_4444);
    access("R2 bus0 disable", 1'b1, 2'd0, 24'd2, 4'd2, 32'h0000_0000);
    access("R6 disabled", 1'b0, 2'd1, 24'd0, 4'd4, 32'd0);
    access("R3 latch after edits", 1'b0, 2'd0, 24'd0, 4'd4, 32'd0);

    access("R10 mmio dev3 read", 1'b0, 2'd2, 24'h00_1824, 4'd4, 32'd0);
    access("R10 mmio dev0 write", 1'b1, 2'd3, 24'h00_0045, 4'd2, 32'hCAFE_F00D);
    access("R10 mmio absent dev4", 1'b0, 2'd2, 24'h00_2000, 4'd6, 32'd0);
    access("R10 mmio wrong bus", 1'b1, 2'd2, 24'h07_0800, 4'd4, 32'h5555_6666);
    access("R10 mmio fn2", 1'b0, 2'd2, 24'h00_0A08, 4'd1, 32'd0);
    idle("R11 tail");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule